// File: doc/BRIEF.md
# Ring-Steered Product Term Summing Stage

This block is the logic-forming front end of one programmable logic block. A shared input bus feeds an AND plane of product terms. Each product term may take every bus signal in true form, in inverted form, or not at all. The logic terms are split into equal groups, one group per sum output. A static steering configuration sends each group to exactly one output, chosen from a window of neighbouring outputs, or parks the group so that it feeds nothing. Each output then ORs every group that arrives at it.

The outputs are joined as a ring, so groups near the top index can feed outputs near index zero. With default parameters there are 68 bus inputs, 32 groups of five logic terms (160 terms), a window of seven groups (35 terms per output), and five control terms that stay outside the sharing network. An output can also be put in a fast mode. In that mode it takes only its own group and ignores the shared network.

The configuration lives in registers that are loaded through a single-word write port. The intended use is to load them while the block is idle. The path from the bus to the outputs is purely combinational.

Top module: `pterm_share_ring`

## Requirements
- R1: Each product term is the AND of its selected literals. A term write puts the literal-select bits for bus bit n at cfgData[n], and the inverted-literal select for bus bit n at cfgData[68+n].
- R2: A term with no literal selected gives 0. A term that selects both forms of one bus bit also gives 0.
- R3: Logic term t of group g has term address g*5+t. Group g with steering offset k, where k is in 0..6, feeds output (g+k) mod 32. Offset 0 is the group's own output.
- R4: Steering wraps around the ring. For example, group 30 with offset 3 feeds output 1.
- R5: One output ORs up to seven groups (35 terms). These are the groups (i-k) mod 32, each with offset k.
- R6: A group with an offset of 7 or more is parked and contributes to no output.
- R7: An output in fast mode presents the OR of its own group's five terms and ignores every group steered to it. Its own group still reaches that group's steered destination.
- R8: An output that is not in fast mode and receives no group is 0.
- R9: Term addresses 160..164 are control terms. They appear on ctrlOut bits 0..4 and never reach any sum output.
- R10: A write at address 165+g sets group g's offset from cfgData[2:0] and output g's fast mode from cfgData[3]. Writes take effect at the rising clock edge where cfgWe is high. Writes to addresses of 197 and above change nothing.
- R11: While rstN is low, all term selects clear, all offsets are parked and fast mode is off, so every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration word address |
| cfgData | input | 136 | Configuration word |
| busIn | input | 68 | Shared input bus |
| sumOut | output | 32 | One summed function per output |
| ctrlOut | output | 5 | Control product terms |

## Verification
The bench targets the ring seam: a group steered past index 31 must land at a low output. A design without the modulo would drop that group or send it to the wrong output. It drives each of seven groups in turn into one output; a window that is one group too short loses the farthest group. It checks that an empty term stays at 0 rather than reading as an all-true AND, and that fast mode both ignores the shared network and leaves its own group's steering intact. It also confirms that out-of-range writes and control terms never disturb the sums, and that a steering write changes nothing before its clock edge.

// File: rtl/pterm_share_pkg.sv
package pterm_share_pkg;
  typedef struct packed {
    logic termWr;
    logic routeWr;
  } cfg_strobe_t;
endpackage

// File: rtl/pterm_cfg_ctrl.sv
module pterm_cfg_ctrl
  import pterm_share_pkg::*;
#(
  parameter int TOTAL_TERMS = 165,
  parameter int GROUPS      = 32,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output cfg_strobe_t       stb,
  output logic [ADDR_W-1:0] rowIdx
);
  localparam logic [ADDR_W-1:0] ROUTE_BASE = ADDR_W'(TOTAL_TERMS);
  localparam logic [ADDR_W-1:0] ROUTE_END  = ADDR_W'(TOTAL_TERMS + GROUPS);

  logic inTerms, inRoutes;

  always_comb begin
    inTerms     = cfgAddr < ROUTE_BASE;
    inRoutes    = (cfgAddr >= ROUTE_BASE) && (cfgAddr < ROUTE_END);
    stb.termWr  = cfgWe && inTerms;
    stb.routeWr = cfgWe && inRoutes;
    rowIdx      = inTerms ? cfgAddr : cfgAddr - ROUTE_BASE;
  end

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.termWr, stb.routeWr}));

  // R10
  strobe_needs_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |-> !(stb.termWr || stb.routeWr));
endmodule

// File: rtl/pterm_and_plane.sv
module pterm_and_plane #(
  parameter int IN_W        = 68,
  parameter int TOTAL_TERMS = 165
) (
  input  logic [IN_W-1:0]        busIn,
  input  logic [IN_W-1:0]        trueSel [TOTAL_TERMS],
  input  logic [IN_W-1:0]        compSel [TOTAL_TERMS],
  output logic [TOTAL_TERMS-1:0] termVec
);
  for (genvar t = 0; t < TOTAL_TERMS; t++) begin : g_term
    logic anyLit;
    logic allMet;
    assign anyLit     = |(trueSel[t] | compSel[t]);
    assign allMet     = &((~trueSel[t] | busIn) & (~compSel[t] | ~busIn));
    assign termVec[t] = anyLit && allMet;
  end
endmodule

// File: rtl/pterm_ring_router.sv
module pterm_ring_router #(
  parameter int GROUPS = 32,
  parameter int GSIZE  = 5,
  parameter int SPAN   = 7,
  parameter int OFF_W  = 3
) (
  input  logic [GROUPS*GSIZE-1:0] logicTerms,
  input  logic [OFF_W-1:0]        offReg [GROUPS],
  input  logic [GROUPS-1:0]       fastReg,
  output logic [GROUPS-1:0]       sumOut
);
  logic [GROUPS-1:0] grpOr;
  logic [SPAN-1:0]   arrive [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grpOr[g] = |logicTerms[g*GSIZE +: GSIZE];
  end

  for (genvar i = 0; i < GROUPS; i++) begin : g_out
    for (genvar k = 0; k < SPAN; k++) begin : g_win
      localparam int SRC = (i - k + GROUPS) % GROUPS;
      assign arrive[i][k] = grpOr[SRC] && (offReg[SRC] == OFF_W'(k));
    end
    assign sumOut[i] = fastReg[i] ? grpOr[i] : |arrive[i];
  end
endmodule

// File: rtl/pterm_share_dp.sv
module pterm_share_dp
  import pterm_share_pkg::*;
#(
  parameter int IN_W   = 68,
  parameter int GROUPS = 32,
  parameter int GSIZE  = 5,
  parameter int CTRL_N = 5,
  parameter int SPAN   = 7,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       stb,
  input  logic [ADDR_W-1:0] rowIdx,
  input  logic [2*IN_W-1:0] cfgData,
  input  logic [IN_W-1:0]   busIn,
  output logic [GROUPS-1:0] sumOut,
  output logic [CTRL_N-1:0] ctrlOut
);
  localparam int LOGIC_TERMS = GROUPS * GSIZE;
  localparam int TOTAL_TERMS = LOGIC_TERMS + CTRL_N;
  localparam int OFF_W       = $clog2(SPAN + 1);
  localparam int GIDX_W      = $clog2(GROUPS);
  localparam logic [OFF_W-1:0] PARK = '1;

  logic [IN_W-1:0]        trueSel [TOTAL_TERMS];
  logic [IN_W-1:0]        compSel [TOTAL_TERMS];
  logic [OFF_W-1:0]       offReg  [GROUPS];
  logic [GROUPS-1:0]      fastReg;
  logic [TOTAL_TERMS-1:0] termVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < TOTAL_TERMS; t++) begin
        trueSel[t] <= '0;
        compSel[t] <= '0;
      end
      for (int g = 0; g < GROUPS; g++) offReg[g] <= PARK;
      fastReg <= '0;
    end else begin
      if (stb.termWr) begin
        trueSel[rowIdx] <= cfgData[IN_W-1:0];
        compSel[rowIdx] <= cfgData[2*IN_W-1:IN_W];
      end
      if (stb.routeWr) begin
        offReg[rowIdx[GIDX_W-1:0]]  <= cfgData[OFF_W-1:0];
        fastReg[rowIdx[GIDX_W-1:0]] <= cfgData[OFF_W];
      end
    end
  end

  pterm_and_plane #(.IN_W(IN_W), .TOTAL_TERMS(TOTAL_TERMS)) u_plane (
    .busIn   (busIn),
    .trueSel (trueSel),
    .compSel (compSel),
    .termVec (termVec)
  );

  pterm_ring_router #(.GROUPS(GROUPS), .GSIZE(GSIZE), .SPAN(SPAN), .OFF_W(OFF_W)) u_ring (
    .logicTerms (termVec[LOGIC_TERMS-1:0]),
    .offReg     (offReg),
    .fastReg    (fastReg),
    .sumOut     (sumOut)
  );

  assign ctrlOut = termVec[TOTAL_TERMS-1:LOGIC_TERMS];

  // R8
  sum_needs_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|sumOut) |-> (|termVec[LOGIC_TERMS-1:0]));

  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (sumOut == '0 && ctrlOut == '0));

  for (genvar i = 0; i < GROUPS; i++) begin : g_fast_chk
    // R7
    fast_own_group_chk: assert property (@(posedge clk) disable iff (!rstN)
      fastReg[i] |-> sumOut[i] == (|termVec[i*GSIZE +: GSIZE]));
  end
endmodule

// File: rtl/pterm_share_ring.sv
module pterm_share_ring
  import pterm_share_pkg::*;
#(
  parameter int IN_W   = 68,
  parameter int GROUPS = 32,
  parameter int GSIZE  = 5,
  parameter int CTRL_N = 5,
  parameter int SPAN   = 7
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        cfgWe,
  input  logic [$clog2(GROUPS*GSIZE+CTRL_N+GROUPS)-1:0] cfgAddr,
  input  logic [2*IN_W-1:0]                           cfgData,
  input  logic [IN_W-1:0]                             busIn,
  output logic [GROUPS-1:0]                           sumOut,
  output logic [CTRL_N-1:0]                           ctrlOut
);
  localparam int TOTAL_TERMS = GROUPS * GSIZE + CTRL_N;
  localparam int ADDR_W      = $clog2(TOTAL_TERMS + GROUPS);

  cfg_strobe_t       stb;
  logic [ADDR_W-1:0] rowIdx;

  pterm_cfg_ctrl #(.TOTAL_TERMS(TOTAL_TERMS), .GROUPS(GROUPS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .stb     (stb),
    .rowIdx  (rowIdx)
  );

  pterm_share_dp #(.IN_W(IN_W), .GROUPS(GROUPS), .GSIZE(GSIZE), .CTRL_N(CTRL_N),
                   .SPAN(SPAN), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rowIdx  (rowIdx),
    .cfgData (cfgData),
    .busIn   (busIn),
    .sumOut  (sumOut),
    .ctrlOut (ctrlOut)
  );
endmodule

// File: tb/tb_pterm_share_ring.sv
module tb_pterm_share_ring;
  localparam int IN_W = 68;
  localparam int GRP  = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cfgWe;
  logic [7:0]        cfgAddr;
  logic [2*IN_W-1:0] cfgData;
  logic [IN_W-1:0]   busIn;
  logic [GRP-1:0]    sumOut;
  logic [4:0]        ctrlOut;
  int checks = 0;
  int errors = 0;

  pterm_share_ring dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .busIn(busIn), .sumOut(sumOut), .ctrlOut(ctrlOut)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0; busIn = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeWord(input int addr, input logic [2*IN_W-1:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 8'(addr); cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic writeTerm(input int idx, input logic [IN_W-1:0] t, input logic [IN_W-1:0] c);
    writeWord(idx, {c, t});
  endtask

  task automatic writeRoute(input int g, input int off, input logic fast);
    writeWord(165 + g, {{(2*IN_W-4){1'b0}}, fast, 3'(off)});
  endtask

  function automatic logic [IN_W-1:0] bitv(input int n);
    return {{(IN_W-1){1'b0}}, 1'b1} << n;
  endfunction

  task automatic setIn(input logic [IN_W-1:0] v);
    @(negedge clk);
    busIn = v;
    #1;
  endtask

  task automatic testReset();
    doReset();
    setIn('1);
    chk("R11 sums after reset", sumOut, 32'h0);
    chk("R11 ctrl after reset", {27'h0, ctrlOut}, 32'h0);
  endtask

  task automatic testLiterals();
    doReset();
    writeTerm(0, bitv(3), bitv(10));
    writeRoute(0, 0, 1'b0);
    setIn(bitv(3));
    chk("R1 true and inverted literal met", sumOut, 32'h1);
    setIn(bitv(3) | bitv(10));
    chk("R1 inverted literal fails", sumOut, 32'h0);
    setIn('0);
    chk("R1 true literal fails", sumOut, 32'h0);
  endtask

  task automatic testEmptyTerm();
    doReset();
    writeRoute(1, 0, 1'b0);
    setIn('1);
    chk("R2 empty term high bus", sumOut, 32'h0);
    setIn('0);
    chk("R2 empty term low bus", sumOut, 32'h0);
    writeTerm(6, bitv(0), bitv(0));
    setIn(bitv(0));
    chk("R2 both forms bus high", sumOut, 32'h0);
    setIn('0);
    chk("R2 both forms bus low", sumOut, 32'h0);
  endtask

  task automatic testSteerPark();
    doReset();
    writeTerm(0, bitv(3), '0);
    writeRoute(0, 2, 1'b0);
    setIn(bitv(3));
    chk("R3 offset 2 lands at output 2", sumOut, 32'h4);
    writeRoute(0, 7, 1'b0);
    setIn(bitv(3));
    chk("R6 parked group feeds nothing", sumOut, 32'h0);
    writeTerm(15, bitv(0), '0);
    writeRoute(3, 1, 1'b0);
    setIn(bitv(0));
    chk("R8 own output empty, neighbour set", sumOut, 32'h10);
  endtask

  task automatic testWrap();
    doReset();
    writeTerm(150, bitv(20), '0);
    writeRoute(30, 3, 1'b0);
    setIn(bitv(20));
    chk("R4 group 30 offset 3 wraps to output 1", sumOut, 32'h2);
  endtask

  task automatic testWide();
    int miss = 0;
    doReset();
    for (int k = 0; k < 7; k++) begin
      int g = (5 - k + GRP) % GRP;
      writeTerm(g * 5 + (k % 5), bitv(40 + k), '0);
      writeRoute(g, k, 1'b0);
    end
    for (int k = 0; k < 7; k++) begin
      setIn(bitv(40 + k));
      if (sumOut !== 32'h20) miss++;
    end
    chk("R5 seven groups each reach output 5 (misses)", 32'(miss), 32'h0);
    setIn('0);
    chk("R5 wide sum idle", sumOut, 32'h0);
  endtask

  task automatic testFast();
    doReset();
    writeTerm(45, bitv(1), '0);
    writeRoute(9, 2, 1'b1);
    writeTerm(50, bitv(2), '0);
    writeRoute(10, 1, 1'b0);
    writeTerm(55, bitv(4), '0);
    setIn(bitv(1));
    chk("R7 fast own group plus its steering", sumOut, 32'hA00);
    setIn(bitv(2));
    chk("R7 shared group at normal output", sumOut, 32'h800);
    writeRoute(11, 7, 1'b1);
    setIn(bitv(2));
    chk("R7 fast output ignores shared group", sumOut, 32'h0);
    setIn(bitv(4));
    chk("R7 fast output takes own parked group", sumOut, 32'h800);
  endtask

  task automatic testCtrl();
    doReset();
    writeTerm(160, bitv(7), '0);
    writeTerm(162, '0, bitv(7));
    for (int g = 0; g < GRP; g++) writeRoute(g, 0, 1'b0);
    setIn(bitv(7));
    chk("R9 ctrl term 0", {27'h0, ctrlOut}, 32'h1);
    chk("R9 ctrl stays out of sums", sumOut, 32'h0);
    setIn('0);
    chk("R9 ctrl term 2", {27'h0, ctrlOut}, 32'h4);
  endtask

  task automatic testWritePort();
    doReset();
    writeTerm(0, bitv(3), '0);
    setIn(bitv(3));
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 8'd165; cfgData = '0;
    #1;
    chk("R10 no effect before edge", sumOut, 32'h0);
    @(negedge clk);
    cfgWe = 1'b0;
    #1;
    chk("R10 effect after edge", sumOut, 32'h1);
    writeWord(197, '1);
    writeWord(255, '1);
    setIn(bitv(3));
    chk("R10 out of range write ignored sums", sumOut, 32'h1);
    chk("R10 out of range write ignored ctrl", {27'h0, ctrlOut}, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0; busIn = '0;
    testReset();
    testLiterals();
    testEmptyTerm();
    testSteerPark();
    testWrap();
    testWide();
    testFast();
    testCtrl();
    testWritePort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule